// File: doc/BRIEF.md
# Register-Run Transfer Sequencer

This block moves a run of data between a byte-addressed memory port and a 32-entry, 32-bit register file. It takes one command at a time and breaks it into single memory accesses, each one a word or a byte. There are two multi-word operations, which move one word per register from the start register up to register 31. There are also two string operations, which move an exact byte count. String operations fill registers big-endian, wrap the register index past 31 back to 0, and clear the unused low bytes of a partial last register.

A command is sampled in the cycle where `cmd_valid` is high and the block is idle. The block then drives a valid/ready request channel, with one access outstanding at a time. Read data comes back a fixed `RD_LAT` cycles after the request handshake. Registers are read and written through a single port. The read data of that port is combinational. For the indexed string-load form the block first checks the operands. If the register range would overwrite the base or index register, it raises an exception and performs no transfer.

Top module: `regrun_mover`

## Requirements
- R1: Op code 2'b00 (multi-word load) loads one 32-bit word per register. It starts at `cmd_reg` and ends with register 31. The address starts at `cmd_addr` and rises by 4 per word. The memory word is big-endian: byte at address A is bits 31:24.
- R2: Op code 2'b01 (multi-word store) writes registers `cmd_reg` through 31 as 32-bit words to rising addresses, using the same byte order. It never writes the register file.
- R3: When `mode_le` is 1, multi-word operations reverse the byte order of every word. String operations (op bit 1 set) never reverse bytes.
- R4: String operations (2'b10 load, 2'b11 store) move whole words while 4 or more bytes remain. After each word the register index rises modulo 32, so 31 is followed by 0.
- R5: A string-load remainder of 1 to 3 bytes is read with byte accesses (`mem_req_byte`=1, data in `mem_rdata[7:0]`). It lands in the next register with the first byte in bits 31:24, each later byte 8 bits lower, and all unfilled bits zero.
- R6: A string-store remainder is written with byte accesses, data in `mem_wdata[7:0]`. The bytes are taken from bits 31:24 of the current register downward, one per rising address.
- R7: When `mode_wide` is 0, every incremented address keeps only its low 32 bits, so address 0xFFFFFFFC is followed by 0. When `mode_wide` is 1, the full 64-bit sum is used.
- R8: A string command with a byte count of 0 makes no access and changes no register. `done` pulses in the cycle after acceptance.
- R9: With `cmd_chk`=1 on a string load, consider the register range from `cmd_reg` up to (not including) `cmd_reg`+`cmd_count`, without wrap. If this range contains `cmd_index`, or a nonzero `cmd_base`, then `exc` pulses for one cycle after acceptance. No access takes place and no `done` is given.
- R10: `busy` is high from the cycle after acceptance until the last access completes. Then `done` is high for exactly one cycle with `busy` low.
- R11: `cmd_valid` is ignored whenever the block is not idle.
- R12: A request holds its address, direction and size unchanged until `mem_req_ready` is seen high. Accesses are issued strictly in address order.
- R13: Load data is taken from `mem_rdata` exactly `RD_LAT` cycles after the request handshake. Registers are written only in that capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | bit1: string, bit0: store |
| cmd_addr | input | AW | Start address |
| cmd_reg | input | 5 | Start register |
| cmd_count | input | CNT_W | Byte count for string operations |
| cmd_chk | input | 1 | Enables the operand overlap check (indexed string load) |
| cmd_base | input | 5 | Base register index for the check |
| cmd_index | input | 5 | Index register index for the check |
| mode_le | input | 1 | Little-endian mode |
| mode_wide | input | 1 | 64-bit address arithmetic |
| mem_req_valid | output | 1 | Access request |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_write | output | 1 | 1 = write |
| mem_req_byte | output | 1 | 1 = byte access, 0 = word |
| mem_addr | output | AW | Access address |
| mem_wdata | output | 32 | Write data (byte in bits 7:0) |
| mem_rdata | input | 32 | Read data, RD_LAT cycles after handshake |
| rf_addr | output | 5 | Register port index |
| rf_rdata | input | 32 | Register read data (combinational) |
| rf_we | output | 1 | Register write enable |
| rf_wdata | output | 32 | Register write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| exc | output | 1 | One-cycle illegal-operand pulse |

## Verification
The checker watches the handshake and status protocol on every cycle. It checks that a stalled request holds steady, and that requests and register writes appear only while busy. It checks that `done` is a lone pulse outside busy, that stores never write registers, and that busy starts only from a command. The data content cannot be shown by a property. This covers byte order, the modulo-32 register wrap, zero-filled partial registers, truncated address steps, the overlap decision and ignored mid-run commands. Only the bench's scenarios show these, by comparing registers, memory and the access address log against a model after each command.

// File: rtl/rmv_pkg.sv
`timescale 1ns/1ps
package rmv_pkg;
  typedef enum logic [1:0] {
    OP_LDM = 2'd0,
    OP_STM = 2'd1,
    OP_LDS = 2'd2,
    OP_STS = 2'd3
  } rmv_op_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_REQ  = 3'd1,
    S_WAIT = 3'd2,
    S_FIN  = 3'd3,
    S_EXC  = 3'd4
  } rmv_st_e;

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/rmv_operand_chk.sv
`timescale 1ns/1ps
module rmv_operand_chk #(
  parameter int CNT_W = 7,
  parameter int RI_W  = 5
) (
  input  logic [RI_W-1:0]  start_i,
  input  logic [RI_W-1:0]  base_i,
  input  logic [RI_W-1:0]  index_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             clash_o
);
  localparam int SUM_W = ((CNT_W > RI_W) ? CNT_W : RI_W) + 1;

  logic [SUM_W-1:0] lo, hi, b, x;
  logic             hit_b, hit_x;

  always_comb begin
    lo    = SUM_W'(start_i);
    hi    = lo + SUM_W'(count_i);
    b     = SUM_W'(base_i);
    x     = SUM_W'(index_i);
    hit_b = (base_i != '0) && (b >= lo) && (b < hi);
    hit_x = (x >= lo) && (x < hi);
    clash_o = hit_b | hit_x;
  end
endmodule

// File: rtl/rmv_addr_step.sv
`timescale 1ns/1ps
module rmv_addr_step #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] addr_i,
  input  logic          word_i,
  input  logic          wide_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] sum;
  assign sum = addr_i + (word_i ? AW'(4) : AW'(1));

  generate
    if (AW > 32) begin : g_wide
      assign addr_o = wide_i ? sum : AW'(sum[31:0]);
    end else begin : g_narrow
      logic unused_wide;
      assign unused_wide = wide_i;
      assign addr_o = sum;
    end
  endgenerate
endmodule

// File: rtl/rmv_lane.sv
`timescale 1ns/1ps
module rmv_lane
  import rmv_pkg::*;
(
  input  logic [31:0] rf_rd_i,
  input  logic [31:0] mem_rd_i,
  input  logic [31:0] acc_i,
  input  logic        swap_i,
  input  logic [1:0]  bpos_i,
  output logic [31:0] st_word_o,
  output logic [31:0] st_byte_o,
  output logic [31:0] ld_word_o,
  output logic [31:0] acc_next_o
);
  logic [4:0] sh;
  assign sh = {~bpos_i, 3'b000};

  assign st_word_o  = swap_i ? swap32(rf_rd_i) : rf_rd_i;
  assign ld_word_o  = swap_i ? swap32(mem_rd_i) : mem_rd_i;
  assign st_byte_o  = {24'd0, 8'(rf_rd_i >> sh)};
  assign acc_next_o = acc_i | (32'(mem_rd_i[7:0]) << sh);
endmodule

// File: rtl/regrun_mover.sv
`timescale 1ns/1ps
module regrun_mover
  import rmv_pkg::*;
#(
  parameter int AW     = 64,
  parameter int CNT_W  = 7,
  parameter int RD_LAT = 1,
  parameter int NREG   = 32,
  localparam int RI_W  = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [RI_W-1:0]  cmd_reg,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             cmd_chk,
  input  logic [RI_W-1:0]  cmd_base,
  input  logic [RI_W-1:0]  cmd_index,
  input  logic             mode_le,
  input  logic             mode_wide,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic             mem_req_byte,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic [RI_W-1:0]  rf_addr,
  input  logic [31:0]      rf_rdata,
  output logic             rf_we,
  output logic [31:0]      rf_wdata,
  output logic             busy,
  output logic             done,
  output logic             exc
);
  localparam int LAT_W = $clog2(RD_LAT + 1);
  localparam logic [RI_W-1:0] LAST_REG = RI_W'(NREG - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  rmv_st_e          st_q, st_d;
  rmv_op_e          op_q, op_d;
  logic [AW-1:0]    addr_q, addr_d, addr_nx;
  logic [RI_W-1:0]  reg_q, reg_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [31:0]      acc_q, acc_d;
  logic [1:0]       bpos_q, bpos_d;
  logic             le_q, le_d, wide_q, wide_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic             dp_en, lat_en;

  logic is_store, is_str, word_acc, last_acc, swap_en, lat_last;
  logic accept, step, clash;
  logic [31:0] st_word, st_byte, ld_word, acc_next;

  assign is_store = op_q[0];
  assign is_str   = op_q[1];
  assign word_acc = !is_str || (left_q >= CNT_W'(4));
  assign last_acc = !is_str   ? (reg_q == LAST_REG) :
                    word_acc  ? (left_q == CNT_W'(4)) : (left_q == CNT_W'(1));
  assign swap_en  = le_q && !is_str;
  assign lat_last = (lat_q == LAT_W'(RD_LAT - 1));
  assign accept   = (st_q == S_IDLE) && cmd_valid;
  assign step     = ((st_q == S_REQ) && mem_req_ready && is_store) ||
                    ((st_q == S_WAIT) && lat_last);

  rmv_operand_chk #(.CNT_W(CNT_W), .RI_W(RI_W)) u_chk_ops (
    .start_i (cmd_reg),
    .base_i  (cmd_base),
    .index_i (cmd_index),
    .count_i (cmd_count),
    .clash_o (clash)
  );

  rmv_addr_step #(.AW(AW)) u_step (
    .addr_i (addr_q),
    .word_i (word_acc),
    .wide_i (wide_q),
    .addr_o (addr_nx)
  );

  rmv_lane u_lane (
    .rf_rd_i    (rf_rdata),
    .mem_rd_i   (mem_rdata),
    .acc_i      (acc_q),
    .swap_i     (swap_en),
    .bpos_i     (bpos_q),
    .st_word_o  (st_word),
    .st_byte_o  (st_byte),
    .ld_word_o  (ld_word),
    .acc_next_o (acc_next)
  );

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE: if (cmd_valid) begin
        if (cmd_op[1] && !cmd_op[0] && cmd_chk && clash) st_d = S_EXC;
        else if (cmd_op[1] && (cmd_count == '0))         st_d = S_FIN;
        else                                             st_d = S_REQ;
      end
      S_REQ: if (mem_req_ready) begin
        if (is_store) st_d = last_acc ? S_FIN : S_REQ;
        else          st_d = S_WAIT;
      end
      S_WAIT: if (lat_last) st_d = last_acc ? S_FIN : S_REQ;
      default: st_d = S_IDLE;
    endcase
  end

  // datapath next values
  always_comb begin
    op_d   = op_q;   addr_d = addr_q; reg_d  = reg_q;  left_d = left_q;
    acc_d  = acc_q;  bpos_d = bpos_q; le_d   = le_q;   wide_d = wide_q;
    dp_en  = accept | step;
    if (accept) begin
      op_d   = rmv_op_e'(cmd_op);
      addr_d = cmd_addr;
      reg_d  = cmd_reg;
      left_d = cmd_count;
      acc_d  = '0;
      bpos_d = '0;
      le_d   = mode_le;
      wide_d = mode_wide;
    end else if (step) begin
      addr_d = addr_nx;
      if (word_acc) begin
        reg_d  = reg_q + 1'b1;
        left_d = left_q - CNT_W'(4);
        acc_d  = '0;
        bpos_d = '0;
      end else begin
        left_d = left_q - CNT_W'(1);
        acc_d  = acc_next;
        bpos_d = bpos_q + 1'b1;
      end
    end
    lat_en = (st_q == S_REQ) || (st_q == S_WAIT);
    lat_d  = (st_q == S_REQ) ? '0 : lat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      op_q <= OP_LDM; addr_q <= '0; reg_q <= '0; left_q <= '0;
      acc_q <= '0; bpos_q <= '0; le_q <= 1'b0; wide_q <= 1'b0;
    end else if (dp_en) begin
      op_q <= op_d; addr_q <= addr_d; reg_q <= reg_d; left_q <= left_d;
      acc_q <= acc_d; bpos_q <= bpos_d; le_q <= le_d; wide_q <= wide_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     lat_q <= '0;
    else if (lat_en) lat_q <= lat_d;
  end

  // outputs
  assign mem_req_valid = (st_q == S_REQ);
  assign mem_req_write = is_store;
  assign mem_req_byte  = !word_acc;
  assign mem_addr      = addr_q;
  assign mem_wdata     = word_acc ? st_word : st_byte;
  assign rf_addr       = reg_q;
  assign rf_we         = (st_q == S_WAIT) && lat_last && (word_acc || last_acc);
  assign rf_wdata      = word_acc ? ld_word : acc_next;
  assign busy          = (st_q == S_REQ) || (st_q == S_WAIT);
  assign done          = (st_q == S_FIN);
  assign exc           = (st_q == S_EXC);
endmodule

// File: rtl/regrun_mover_chk.sv
`timescale 1ns/1ps
module regrun_mover_chk #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic          mem_req_byte,
  input logic [AW-1:0] mem_addr,
  input logic          rf_we,
  input logic          busy,
  input logic          done,
  input logic          exc
);
  p_req_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !exc));
  p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_addr) && $stable(mem_req_write) && $stable(mem_req_byte)));
  p_exc_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> (!busy && !done && !rf_we));
  p_exc_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc |=> !exc);
  p_start_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));
  p_rfwe_wait_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (busy && !mem_req_valid));
  p_store_no_rf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !mem_req_write);
endmodule

bind regrun_mover regrun_mover_chk #(.AW(AW)) u_props (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_byte  (mem_req_byte),
  .mem_addr      (mem_addr),
  .rf_we         (rf_we),
  .busy          (busy),
  .done          (done),
  .exc           (exc)
);

// File: tb/regrun_mover_tb.sv
`timescale 1ns/1ps
module regrun_mover_tb;
  localparam int AW = 64;
  localparam int CW = 7;
  localparam int LAT = 1;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic          cmd_valid, cmd_chk, mode_le, mode_wide;
  logic [1:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [4:0]    cmd_reg, cmd_base, cmd_index;
  logic [CW-1:0] cmd_count;
  logic          mem_req_valid, mem_req_ready, mem_req_write, mem_req_byte;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [4:0]    rf_addr;
  logic [31:0]   rf_rdata, rf_wdata;
  logic          rf_we, busy, done, exc;

  regrun_mover #(.AW(AW), .CNT_W(CW), .RD_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_reg(cmd_reg), .cmd_count(cmd_count),
    .cmd_chk(cmd_chk), .cmd_base(cmd_base), .cmd_index(cmd_index),
    .mode_le(mode_le), .mode_wide(mode_wide),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_byte(mem_req_byte),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_addr(rf_addr), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .busy(busy), .done(done), .exc(exc)
  );

  // environment: register file and byte memory
  logic [31:0] rf [32];
  logic [7:0]  mem [1024];
  logic [31:0] exp_rf [32];
  logic [7:0]  exp_mem [1024];
  logic [63:0] act_log [256];
  logic [63:0] exp_log [256];
  int n_act, n_exp;
  int checks = 0, fails = 0;
  int ready_mode = 1;   // 0 always ready, 1 random

  assign rf_rdata = rf[rf_addr];

  always @(posedge clk) begin
    if (rf_we) rf[rf_addr] <= rf_wdata;
    if (mem_req_valid && mem_req_ready) begin
      act_log[n_act[7:0]] <= mem_addr;
      n_act <= n_act + 1;
      if (mem_req_write) begin
        if (mem_req_byte) mem[mem_addr[9:0]] <= mem_wdata[7:0];
        else begin
          mem[mem_addr[9:0]]          <= mem_wdata[31:24];
          mem[10'(mem_addr[9:0] + 1)] <= mem_wdata[23:16];
          mem[10'(mem_addr[9:0] + 2)] <= mem_wdata[15:8];
          mem[10'(mem_addr[9:0] + 3)] <= mem_wdata[7:0];
        end
      end else begin
        if (mem_req_byte) mem_rdata <= {24'd0, mem[mem_addr[9:0]]};
        else mem_rdata <= {mem[mem_addr[9:0]], mem[10'(mem_addr[9:0] + 1)],
                           mem[10'(mem_addr[9:0] + 2)], mem[10'(mem_addr[9:0] + 3)]};
      end
    end
  end

  always @(negedge clk)
    mem_req_ready <= (ready_mode == 0) ? 1'b1 : (($urandom % 4) != 0);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [63:0] nxt(input logic [63:0] a, input int inc, input bit wide);
    logic [63:0] s;
    s = a + 64'(inc);
    return wide ? s : {32'd0, s[31:0]};
  endfunction

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // reference model on exp_* arrays
  task automatic model(input logic [1:0] op, input logic [63:0] a0, input int r0,
                       input int cnt, input bit chkf, input int base, input int idx,
                       input bit le, input bit wide, output bit ex);
    logic [63:0] a;
    logic [31:0] w;
    int r, n, sh;
    bit clash;
    a = a0; r = r0; n = cnt; ex = 0; n_exp = 0;
    clash = 0;
    for (int k = 0; k < cnt; k++) begin
      if ((r0 + k) == idx) clash = 1;
      if (base != 0 && (r0 + k) == base) clash = 1;
    end
    if (op == 2'b10 && chkf && clash) begin ex = 1; return; end
    if (!op[1]) begin
      for (int q = r0; q < 32; q++) begin
        exp_log[n_exp] = a; n_exp++;
        if (op[0]) begin
          w = le ? bsw(exp_rf[q]) : exp_rf[q];
          for (int j = 0; j < 4; j++) exp_mem[10'(a[9:0] + 10'(j))] = w[31-8*j -: 8];
        end else begin
          for (int j = 0; j < 4; j++) w[31-8*j -: 8] = exp_mem[10'(a[9:0] + 10'(j))];
          exp_rf[q] = le ? bsw(w) : w;
        end
        a = nxt(a, 4, wide);
      end
    end else begin
      while (n >= 4) begin
        exp_log[n_exp] = a; n_exp++;
        if (op[0]) for (int j = 0; j < 4; j++) exp_mem[10'(a[9:0] + 10'(j))] = exp_rf[r][31-8*j -: 8];
        else for (int j = 0; j < 4; j++) exp_rf[r][31-8*j -: 8] = exp_mem[10'(a[9:0] + 10'(j))];
        r = (r + 1) % 32; a = nxt(a, 4, wide); n -= 4;
      end
      if (n > 0 && !op[0]) exp_rf[r] = 32'd0;
      sh = 24;
      while (n > 0) begin
        exp_log[n_exp] = a; n_exp++;
        if (op[0]) exp_mem[a[9:0]] = exp_rf[r][sh +: 8];
        else exp_rf[r][sh +: 8] = exp_mem[a[9:0]];
        a = nxt(a, 1, wide); sh -= 8; n--;
      end
    end
  endtask

  task automatic run(input string tag, input logic [1:0] op, input logic [63:0] a0,
                     input int r0, input int cnt, input bit chkf, input int base,
                     input int idx, input bit le, input bit wide, input bit inject);
    bit ex_exp, saw_done, saw_exc;
    int gap, cyc;
    for (int i = 0; i < 32; i++) begin rf[i] = $urandom; exp_rf[i] = rf[i]; end
    for (int i = 0; i < 1024; i++) begin mem[i] = 8'($urandom); exp_mem[i] = mem[i]; end
    model(op, a0, r0, cnt, chkf, base, idx, le, wide, ex_exp);
    n_act = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a0; cmd_reg = 5'(r0); cmd_count = CW'(cnt);
    cmd_chk = chkf; cmd_base = 5'(base); cmd_index = 5'(idx); mode_le = le; mode_wide = wide;
    @(negedge clk);
    cmd_valid = 0;
    gap = 0; cyc = 0; saw_done = 0; saw_exc = 0;
    while (cyc < 3000) begin
      if (done) begin saw_done = 1; break; end
      if (exc)  begin saw_exc = 1; break; end
      if (!busy) gap++;
      if (inject && cyc == 2) begin
        cmd_valid = 1; cmd_op = ~op; cmd_reg = 5'd0; cmd_count = CW'(9); cmd_addr = 64'h200;
      end else cmd_valid = 0;
      @(negedge clk); cyc++;
    end
    cmd_valid = 0;
    chk(saw_exc == ex_exp, tag, "exception flag", 64'(saw_exc), 64'(ex_exp));
    chk(saw_done == !ex_exp, tag, "done seen", 64'(saw_done), 64'(!ex_exp));
    chk(gap == 0, "R10", "busy gap cycles", 64'(gap), 0);
    @(negedge clk);
    chk(!done && !exc && !busy, "R10", "pulse width/idle", {61'd0, done, exc, busy}, 0);
    for (int i = 0; i < 32; i++)
      if (rf[i] !== exp_rf[i]) begin chk(0, tag, $sformatf("reg %0d", i), 64'(rf[i]), 64'(exp_rf[i])); break; end
    chk(1, tag, "regs", 0, 0);
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== exp_mem[i]) begin chk(0, tag, $sformatf("mem %0d", i), 64'(mem[i]), 64'(exp_mem[i])); break; end
    chk(n_act == n_exp, tag, "access count", 64'(n_act), 64'(n_exp));
    for (int i = 0; i < n_exp && i < n_act; i++)
      if (act_log[i] !== exp_log[i]) begin chk(0, "R12", $sformatf("addr %0d", i), act_log[i], exp_log[i]); break; end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 64'd1, 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    n_act = 0; cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_reg = 0; cmd_count = 0;
    cmd_chk = 0; cmd_base = 0; cmd_index = 0; mode_le = 0; mode_wide = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !exc && !mem_req_valid && !rf_we, "R10", "reset state",
        {59'd0, busy, done, exc, mem_req_valid, rf_we}, 0);

    // directed corners
    run("R1",  2'b00, 64'h100, 28, 0, 0, 0, 0, 0, 1, 0);
    ready_mode = 0;
    run("R13", 2'b00, 64'h040, 26, 0, 0, 0, 0, 0, 1, 0);
    ready_mode = 1;
    run("R2",  2'b01, 64'h180, 29, 0, 0, 0, 0, 0, 1, 0);
    run("R3",  2'b01, 64'h080, 29, 0, 0, 0, 0, 1, 1, 0);
    run("R3",  2'b00, 64'h0C2, 30, 0, 0, 0, 0, 1, 1, 0);
    run("R3",  2'b10, 64'h010, 5, 8, 0, 0, 0, 1, 1, 0);
    run("R4",  2'b10, 64'h200, 30, 12, 0, 0, 0, 0, 1, 0);
    run("R4",  2'b11, 64'h230, 31, 8, 0, 0, 0, 0, 1, 0);
    run("R5",  2'b10, 64'h301, 3, 7, 0, 0, 0, 0, 1, 0);
    run("R5",  2'b10, 64'h305, 31, 1, 0, 0, 0, 0, 1, 0);
    run("R6",  2'b11, 64'h123, 10, 6, 0, 0, 0, 0, 1, 0);
    run("R6",  2'b11, 64'h201, 2, 3, 0, 0, 0, 0, 1, 0);
    run("R7",  2'b00, 64'h0000_0000_FFFF_FFF8, 28, 0, 0, 0, 0, 0, 0, 0);
    run("R7",  2'b00, 64'h0000_0000_FFFF_FFF8, 28, 0, 0, 0, 0, 0, 1, 0);
    run("R7",  2'b10, 64'h0000_0000_FFFF_FFFE, 4, 5, 0, 0, 0, 0, 0, 0);
    run("R8",  2'b10, 64'h050, 7, 0, 0, 0, 0, 0, 1, 0);
    run("R8",  2'b11, 64'h050, 7, 0, 0, 0, 0, 0, 1, 0);
    run("R9",  2'b10, 64'h060, 4, 9, 1, 6, 20, 0, 1, 0);
    run("R9",  2'b10, 64'h060, 4, 9, 1, 1, 12, 0, 1, 0);
    run("R9",  2'b10, 64'h060, 4, 9, 1, 4, 20, 0, 1, 0);
    run("R9",  2'b10, 64'h060, 0, 9, 1, 0, 20, 0, 1, 0);
    run("R9",  2'b10, 64'h060, 4, 9, 1, 13, 3, 0, 1, 0);
    run("R11", 2'b00, 64'h140, 20, 0, 0, 0, 0, 0, 1, 1);
    run("R11", 2'b11, 64'h140, 20, 30, 0, 0, 0, 0, 1, 1);

    // constrained random
    for (int t = 0; t < 40; t++) begin
      logic [1:0] op;
      int r0, cnt, b, x;
      op = 2'($urandom); r0 = int'($urandom % 32); cnt = int'($urandom % 40);
      b = int'($urandom % 32); x = int'($urandom % 32);
      case (op)
        2'b00: run("R1", op, 64'($urandom % 1024), r0, cnt, 0, b, x, 1'($urandom), 1'($urandom), 0);
        2'b01: run("R2", op, 64'($urandom % 1024), r0, cnt, 0, b, x, 1'($urandom), 1'($urandom), 0);
        2'b10: run("R9", op, 64'($urandom % 1024), r0, cnt, 1'($urandom), b, x, 1'($urandom), 1, 0);
        default: run("R6", op, 64'($urandom % 1024), r0, cnt, 0, b, x, 1'($urandom), 1, 0);
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule